// File: doc/BRIEF.md
# Streaming 3x3 Matrix Transposer

This block takes a 3x3 matrix as a stream of nine elements, one per clock, in row-major order. It returns the same nine elements, one per clock, in column-major order. Frames may follow one another with no idle cycle between them, and the output stream then has no gaps either.

The block does not use a nine-entry frame buffer. It keeps every element in a chain of four data registers, which is the smallest number that covers all values alive at the same time. Values mostly move forward one register per clock. At three fixed points in each nine-cycle period, a value is sent from the last register back to an earlier free register. A phase counter that counts modulo nine controls every register multiplexer and the output select. The first element reaches the output four clocks after it enters. The element in row 2, column 0 is never stored: it goes straight from the input to the output in the cycle it arrives.

A source marks the start of a frame by raising `in_valid` while the block is idle, or on the cycle right after the previous frame's last element. When a stream ends, the block keeps running for four more cycles to deliver the tail of the last frame, and then it goes idle.

Top module: `mtx3_transposer`

## Requirements
- R1: While `rst` is high, and after it until the first frame starts, `out_valid` is 0.
- R2: When the block is idle and `in_valid` is 1, that cycle's `in_data` is taken as the element at row 0, column 0. The next eight cycles carry the rest of the matrix row by row: (0,1), (0,2), (1,0), ..., (2,2).
- R3: The nine elements of a frame leave on nine consecutive cycles in column order: (0,0), (1,0), (2,0), (0,1), (1,1), (2,1), (0,2), (1,2), (2,2). `out_valid` is 1 on each of these cycles.
- R4: Element (0,0) appears on `out_data`, with `out_valid` 1, exactly four cycles after the cycle in which it was presented.
- R5: If `in_valid` is 1 on the cycle right after a frame's ninth element, a new frame starts there. The output stream then continues with no cycle in which `out_valid` is 0.
- R6: Once a frame has started, `in_valid` is ignored for its remaining eight cycles. All nine cycles are taken as elements, even if `in_valid` drops.
- R7: If `in_valid` is 0 on the cycle after a frame's ninth element, the last four outputs (1,2)... specifically (2,1), (0,2), (1,2) and (2,2) still emerge on the following cycles. After that, `out_valid` returns to 0 and stays 0 until a new frame starts.
- R8: Element (2,0) appears on `out_data` in the same cycle in which it is on `in_data`.
- R9: After a stream ends, a new frame may start on the fifth cycle after the previous ninth element, or on any later cycle. It again shows the four-cycle latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Frame start marker; sampled only at a frame boundary or while idle |
| in_data | input | DATA_W | Matrix element, row-major order |
| out_valid | output | 1 | High while `out_data` carries a transposed element |
| out_data | output | DATA_W | Matrix element, column-major order |

## Verification
The assertions assume that frames are always whole and aligned. After a ninth element, the source either raises `in_valid` on the very next cycle or holds it low for at least four cycles, so that a start never falls inside a drain. Under that assumption, each checked output can be traced back a fixed number of cycles to the input it came from. The stimulus keeps to this rule: it sends back-to-back runs, a restart after a gap of exactly four idle cycles, and a restart after a longer gap. It drops `in_valid` only inside a frame that has already started, where the block ignores it.

// File: rtl/mtx3_xpose_pkg.sv
package mtx3_xpose_pkg;

  localparam int unsigned SIDE     = 3;
  localparam int unsigned ELEMS    = SIDE * SIDE;
  // Four registers cover the peak number of live values over a frame.
  localparam int unsigned SLOTS    = 4;
  localparam int unsigned LATENCY  = 4;
  localparam int unsigned PHASE_W  = $clog2(ELEMS);
  localparam int unsigned SECOND   = 1;

  typedef logic [PHASE_W-1:0] phase_t;

  localparam phase_t LAST_PHASE = phase_t'(ELEMS - 1);
  localparam phase_t DRAIN_END  = phase_t'(LATENCY - 1);

  typedef enum logic [1:0] {
    TAP_TAIL   = 2'd0,
    TAP_SECOND = 2'd1,
    TAP_INPUT  = 2'd2
  } tap_e;

  typedef enum logic {
    FEED_FWD  = 1'b0,
    FEED_BACK = 1'b1
  } feed_e;

  // Where register `slot` loads from at the end of a cycle in phase `ph`.
  // The normal move is forward from the previous register. A value still
  // alive in the tail register is sent back to slot 0 after phase 6, and
  // to slot 2 after phases 5 and 0.
  function automatic feed_e slot_feed(input int unsigned slot, input phase_t ph);
    feed_e f;
    f = FEED_FWD;
    if (slot == 0 && ph == phase_t'(6))
      f = FEED_BACK;
    if (slot == 2 && (ph == phase_t'(5) || ph == phase_t'(0)))
      f = FEED_BACK;
    return f;
  endfunction

  // Which source drives the output in phase `ph`.
  function automatic tap_e out_tap(input phase_t ph);
    tap_e t;
    case (ph)
      phase_t'(6):              t = TAP_INPUT;
      phase_t'(0), phase_t'(5): t = TAP_SECOND;
      default:                  t = TAP_TAIL;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/mtx3_phase_seq.sv
module mtx3_phase_seq
  import mtx3_xpose_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   in_valid,
  output phase_t phase,
  output logic   out_valid
);

  phase_t ph_q;
  logic   cur_q;   // frame whose first element entered at the last phase 0
  logic   prev_q;  // frame before that, still draining in phases 1..3

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= '0;
      cur_q  <= 1'b0;
      prev_q <= 1'b0;
    end else if (ph_q == '0) begin
      if (in_valid || cur_q) begin
        ph_q   <= phase_t'(1);
        prev_q <= cur_q;
        cur_q  <= in_valid;
      end
    end else if (ph_q == DRAIN_END && !cur_q) begin
      ph_q   <= '0;
      prev_q <= 1'b0;
    end else if (ph_q == LAST_PHASE) begin
      ph_q <= '0;
    end else begin
      ph_q <= ph_q + phase_t'(1);
    end
  end

  assign phase     = ph_q;
  assign out_valid = (ph_q == '0 || ph_q > DRAIN_END) ? cur_q : prev_q;

endmodule

// File: rtl/mtx3_reg_chain.sv
module mtx3_reg_chain
  import mtx3_xpose_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  phase_t                        phase,
  input  logic [DATA_W-1:0]             din,
  output logic [SLOTS-1:0][DATA_W-1:0]  slot
);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [DATA_W-1:0] fwd_src;
    logic [DATA_W-1:0] nxt;
    logic [DATA_W-1:0] q;

    if (s == 0) begin : g_head
      assign fwd_src = din;
    end else begin : g_body
      assign fwd_src = slot[s-1];
    end

    assign nxt = (slot_feed(s, phase) == FEED_BACK) ? slot[SLOTS-1] : fwd_src;

    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= nxt;
    end

    assign slot[s] = q;
  end

endmodule

// File: rtl/mtx3_out_mux.sv
module mtx3_out_mux
  import mtx3_xpose_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  phase_t                        phase,
  input  logic [DATA_W-1:0]             din,
  input  logic [SLOTS-1:0][DATA_W-1:0]  slot,
  output logic [DATA_W-1:0]             dout
);

  always_comb begin
    unique case (out_tap(phase))
      TAP_INPUT:  dout = din;
      TAP_SECOND: dout = slot[SECOND];
      default:    dout = slot[SLOTS-1];
    endcase
  end

endmodule

// File: rtl/mtx3_transposer.sv
module mtx3_transposer
  import mtx3_xpose_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  phase_t                       phase;
  logic [SLOTS-1:0][DATA_W-1:0] slots;

  mtx3_phase_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .phase     (phase),
    .out_valid (out_valid)
  );

  mtx3_reg_chain #(.DATA_W(DATA_W)) u_chain (
    .clk   (clk),
    .rst   (rst),
    .phase (phase),
    .din   (in_data),
    .slot  (slots)
  );

  mtx3_out_mux #(.DATA_W(DATA_W)) u_mux (
    .phase (phase),
    .din   (in_data),
    .slot  (slots),
    .dout  (out_data)
  );

endmodule

// File: rtl/mtx3_transposer_chk.sv
module mtx3_transposer_chk
  import mtx3_xpose_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input phase_t            phase
);

  // R1: an idle block with no start request stays idle and silent
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (phase == '0 && !in_valid && !out_valid) |=> (!out_valid && phase == '0));

  // R2: a start request at phase 0 moves the sequence into the frame
  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    (phase == '0 && in_valid) |=> (phase == phase_t'(1)));

  // R2: the phase never leaves the frame range
  p_phase_range_r2: assert property (@(posedge clk) disable iff (rst)
    phase <= LAST_PHASE);

  // R4: the first element comes out four cycles after a frame start
  p_first_out_r4: assert property (@(posedge clk) disable iff (rst)
    (phase == '0 && in_valid) |-> ##4 (out_valid && out_data == $past(in_data, 4)));

  // R3: (0,1) entered six cycles before it leaves
  p_order_b_r3: assert property (@(posedge clk) disable iff (rst)
    (phase == phase_t'(7) && out_valid) |-> out_data == $past(in_data, 6));

  // R3: (0,2) entered eight cycles before it leaves, across the frame boundary
  p_order_c_r3: assert property (@(posedge clk) disable iff (rst)
    (phase == phase_t'(1) && out_valid) |-> out_data == $past(in_data, 8));

  // R8: (2,0) passes through in the same cycle
  p_bypass_r8: assert property (@(posedge clk) disable iff (rst)
    (phase == phase_t'(6) && out_valid) |-> out_data == in_data);

  // R5: at a boundary with a valid output, the stream keeps going
  p_no_bubble_r5: assert property (@(posedge clk) disable iff (rst)
    (phase == '0 && out_valid) |=> out_valid);

  // R7: with no new frame, the drain ends four cycles later
  p_drain_end_r7: assert property (@(posedge clk) disable iff (rst)
    (phase == '0 && !in_valid && out_valid) |-> ##4 (!out_valid && phase == '0));

endmodule

bind mtx3_transposer mtx3_transposer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_data  (out_data),
  .phase     (phase)
);

// File: tb/mtx3_transposer_tb_top.sv
module mtx3_transposer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 8;
  localparam int LAT        = 4;
  localparam int WATCHDOG   = 5000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic              out_valid;
  logic [DATA_W-1:0] out_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  mtx3_transposer #(.DATA_W(DATA_W)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit finished = 1'b0;

  // Reference model: expected output value and requirement tag per cycle
  int    exp_val [int];
  string exp_tag [int];

  task automatic chk(input string req, input string what,
                     input logic [31:0] actual, input logic [31:0] expected);
    n_checks++;
    if (actual !== expected) begin
      n_fail++;
      $display("FAIL %s %s cycle %0d: actual=%0h expected=%0h",
               req, what, cyc, actual, expected);
    end
  endtask

  task automatic tick(input logic v, input logic [DATA_W-1:0] d, input string idle_req);
    @(negedge clk);
    in_valid = v;
    in_data  = d;
    #1;
    if (exp_val.exists(cyc)) begin
      chk(exp_tag[cyc], "out_valid", 32'(out_valid), 32'd1);
      chk(exp_tag[cyc], "out_data", 32'(out_data), 32'(exp_val[cyc]));
      exp_val.delete(cyc);
      exp_tag.delete(cyc);
    end else begin
      chk(idle_req, "out_valid", 32'(out_valid), 32'd0);
    end
    cyc++;
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) tick(1'b0, DATA_W'($urandom), req);
  endtask

  // counting=1 gives elements 1..9; holes=1 drops in_valid mid-frame (R6)
  task automatic send_frame(input string main_req, input string tail_req,
                            input bit counting, input bit holes);
    logic [DATA_W-1:0] elem [9];
    int s;
    s = cyc;
    for (int k = 0; k < 9; k++) begin
      int r, c, pos;
      elem[k] = counting ? DATA_W'(k + 1) : DATA_W'($urandom);
      r   = k / 3;
      c   = k % 3;
      pos = c * 3 + r;
      exp_val[s + LAT + pos] = int'(elem[k]);
      if (pos == 0)      exp_tag[s + LAT + pos] = "R4";
      else if (k == 6)   exp_tag[s + LAT + pos] = "R8";
      else if (pos >= 5) exp_tag[s + LAT + pos] = tail_req;
      else               exp_tag[s + LAT + pos] = main_req;
    end
    for (int k = 0; k < 9; k++)
      tick((holes && (k == 3 || k == 5)) ? 1'b0 : 1'b1, elem[k], main_req);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1;
      chk("R1", "out_valid in reset", 32'(out_valid), 32'd0);
    end
    rst = 1'b0;
    idle(3, "R1");
    // back-to-back stream of three frames
    send_frame("R2", "R5", 1'b0, 1'b0);
    send_frame("R3", "R5", 1'b1, 1'b0);
    send_frame("R6", "R7", 1'b0, 1'b1);
    // minimum gap of four idle cycles, then restart
    idle(4, "R7");
    send_frame("R9", "R5", 1'b0, 1'b0);
    send_frame("R5", "R7", 1'b0, 1'b0);
    idle(11, "R7");
    send_frame("R9", "R7", 1'b1, 1'b0);
    idle(12, "R7");
    n_checks++;
    if (exp_val.num() != 0) begin
      n_fail++;
      $display("FAIL R7 outputs missing: actual=%0d expected=0", exp_val.num());
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R3 watchdog: actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule